// File: doc/BRIEF.md
# Signed Extremes Tracker with Clear-on-Read

This block watches a stream of signed 24-bit results. Each result carries a 2-bit channel tag. The block keeps two trackers. One holds the largest value seen since it was last cleared, and the other holds the smallest. Each tracker also stores the channel that produced its value. Software or a neighbouring block reads either tracker as a 32-bit word through a one-cycle read strobe.

Reading a tracker returns its contents. It then reloads the tracker with the opposite extreme of the signed range, so the next sample to arrive always replaces it. A sample that arrives in the same cycle as a read is not lost. The read returns the old word, and the sample is compared against the freshly reloaded value.

Top module: `extremes_tracker`

## Requirements
- R1: After reset, the maximum word reads 0x80000000 and the minimum word reads 0x7FFFFF00.
- R2: Both words share one layout: the stored value in bits 31:8, the channel in bits 1:0, and bits 7:2 always zero.
- R3: A valid sample replaces the stored maximum, and its channel, only when the sample is strictly greater in two's-complement order.
- R4: A valid sample replaces the stored minimum, and its channel, only when the sample is strictly smaller in two's-complement order.
- R5: A sample equal to a stored extreme leaves that tracker's value and channel unchanged.
- R6: `rd_data` shows the maximum word when `rd_sel` is 0 and the minimum word when `rd_sel` is 1. It shows the word in the same cycle, before any side effect of the read.
- R7: A cycle with `rd_en`=1 and `rd_sel`=0 reloads the maximum to 0x800000 with channel 0 from the next cycle on. The minimum tracker is left untouched.
- R8: A cycle with `rd_en`=1 and `rd_sel`=1 reloads the minimum to 0x7FFFFF with channel 0 from the next cycle on. The maximum tracker is left untouched.
- R9: When a sample and a read of a tracker fall in the same cycle, the read returns the old word. The sample is then judged against the reloaded value, so any sample other than the reload value itself becomes the new content.
- R10: In a cycle with neither a valid sample nor a read, both trackers hold their value and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed sample value |
| smp_chan | input | 2 | Channel tag of the sample |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | 1 | Word select: 0 for maximum, 1 for minimum |
| rd_data | output | 32 | Selected packed word |

## Verification
The read word is combinational. The bench samples `rd_data` 1 ns after it drives the inputs on a falling edge, within the same cycle as the read. A sample or a read-reload takes effect at the next rising edge. The bench therefore checks its result through a plain read at the following falling edge, which is one cycle after the stimulus. The same-cycle cases follow one rule: the word returned at a falling edge predates the rising edge that applies both the reload and the sample.

// File: rtl/ext_trk_pkg.sv
package ext_trk_pkg;

  typedef enum logic {
    SEL_MAX = 1'b0,
    SEL_MIN = 1'b1
  } word_sel_e;

  typedef enum logic {
    TRK_MAX = 1'b0,
    TRK_MIN = 1'b1
  } trk_kind_e;

endpackage

// File: rtl/extreme_slot.sv
module extreme_slot
  import ext_trk_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CHAN_W = 2,
  parameter trk_kind_e   KIND   = TRK_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic              clr,
  output logic [DATA_W-1:0] val_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic              take
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] RELOAD   = (KIND == TRK_MAX) ? MOST_NEG : MOST_POS;

  // strict signed ordering in the direction this slot tracks
  function automatic logic beats(input logic [DATA_W-1:0] cand,
                                 input logic [DATA_W-1:0] held);
    if (KIND == TRK_MAX) return $signed(cand) > $signed(held);
    else                 return $signed(cand) < $signed(held);
  endfunction

  logic [DATA_W-1:0] base_val;
  logic [CHAN_W-1:0] base_chan;

  // a read reloads first, then the sample is judged against the reload
  assign base_val  = clr ? RELOAD : val_q;
  assign base_chan = clr ? '0     : chan_q;
  assign take      = smp_vld && beats(smp_data, base_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= RELOAD;
      chan_q <= '0;
    end else if (take) begin
      val_q  <= smp_data;
      chan_q <= smp_chan;
    end else begin
      val_q  <= base_val;
      chan_q <= base_chan;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (val_q == $past(smp_data)) && (chan_q == $past(smp_chan)));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !smp_vld) |=> (val_q == RELOAD) && (chan_q == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !smp_vld) |=> $stable(val_q) && $stable(chan_q));

  // R5
  equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !clr && (smp_data == val_q)) |=> $stable(val_q) && $stable(chan_q));

  // R4
  generate
    if (KIND == TRK_MAX) begin : g_mono_max
      mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $signed(val_q) >= $signed($past(val_q)));
    end else begin : g_mono_min
      mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $signed(val_q) <= $signed($past(val_q)));
    end
  endgenerate

endmodule

// File: rtl/word_packer.sv
module word_packer
  import ext_trk_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CHAN_W = 2,
  parameter int unsigned REG_W  = 32
) (
  input  logic [DATA_W-1:0] max_val,
  input  logic [CHAN_W-1:0] max_chan,
  input  logic [DATA_W-1:0] min_val,
  input  logic [CHAN_W-1:0] min_chan,
  input  word_sel_e         sel,
  output logic [REG_W-1:0]  word
);

  localparam int unsigned PAD_W = REG_W - DATA_W - CHAN_W;

  function automatic logic [REG_W-1:0] pack(input logic [DATA_W-1:0] v,
                                            input logic [CHAN_W-1:0] c);
    return {v, {PAD_W{1'b0}}, c};
  endfunction

  assign word = (sel == SEL_MIN) ? pack(min_val, min_chan) : pack(max_val, max_chan);

endmodule

// File: rtl/extremes_tracker.sv
module extremes_tracker
  import ext_trk_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CHAN_W = 2,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data
);

  localparam int unsigned VAL_LSB = REG_W - DATA_W;

  word_sel_e         sel;
  logic              clr_max, clr_min;
  logic              take_max, take_min;
  logic [DATA_W-1:0] max_val, min_val;
  logic [CHAN_W-1:0] max_chan, min_chan;

  assign sel     = word_sel_e'(rd_sel);
  assign clr_max = rd_en && (sel == SEL_MAX);
  assign clr_min = rd_en && (sel == SEL_MIN);

  extreme_slot #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .KIND(TRK_MAX)) u_max (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .smp_chan(smp_chan), .clr(clr_max), .val_q(max_val), .chan_q(max_chan),
    .take(take_max)
  );

  extreme_slot #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .KIND(TRK_MIN)) u_min (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .smp_chan(smp_chan), .clr(clr_min), .val_q(min_val), .chan_q(min_chan),
    .take(take_min)
  );

  word_packer #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .REG_W(REG_W)) u_pack (
    .max_val(max_val), .max_chan(max_chan), .min_val(min_val),
    .min_chan(min_chan), .sel(sel), .word(rd_data)
  );

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[VAL_LSB-1:CHAN_W] == '0);

  // R6
  word_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:VAL_LSB] == ((sel == SEL_MIN) ? min_val : max_val));

  // R8
  other_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_min && !smp_vld) |=> $stable(max_val) && $stable(max_chan));

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_max && smp_vld && (smp_data != {1'b1, {(DATA_W-1){1'b0}}}))
      |=> max_val == $past(smp_data));

endmodule

// File: tb/extremes_tracker_tb_top.sv
`timescale 1ns/1ps
module extremes_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_data = '0;
  logic [1:0]  smp_chan = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [23:0] m_max, m_min;
  logic [1:0]  m_maxc, m_minc;

  always #4 clk = ~clk;

  extremes_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .smp_chan(smp_chan), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [31:0] word_of(input logic [23:0] v, input logic [1:0] c);
    logic [31:0] w;
    w = '0;
    w[31:8] = v;
    w[1:0]  = c;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns the word seen in that cycle and updates the model
  task automatic step(input logic v, input logic [23:0] d, input logic [1:0] c,
                      input logic re, input logic s, output logic [31:0] seen);
    @(negedge clk);
    smp_vld = v; smp_data = d; smp_chan = c; rd_en = re; rd_sel = s;
    #1 seen = rd_data;
    if (re && !s) begin m_max = 24'h800000; m_maxc = 2'd0; end
    if (re && s)  begin m_min = 24'h7FFFFF; m_minc = 2'd0; end
    if (v && ($signed(d) > $signed(m_max))) begin m_max = d; m_maxc = c; end
    if (v && ($signed(d) < $signed(m_min))) begin m_min = d; m_minc = c; end
  endtask

  task automatic peek(input logic s, output logic [31:0] seen);
    step(1'b0, 24'h0, 2'd0, 1'b0, s, seen);
  endtask

  task automatic t_reset;
    logic [31:0] w;
    peek(1'b0, w); check("R1 max after reset", w, 32'h80000000);
    peek(1'b1, w); check("R1 min after reset", w, 32'h7FFFFF00);
  endtask

  task automatic t_samples;
    logic [31:0] w;
    step(1'b1, 24'h000100, 2'd1, 1'b0, 1'b0, w);
    peek(1'b0, w); check("R3 R2 first sample max", w, 32'h00010001);
    peek(1'b1, w); check("R4 first sample min", w, 32'h00010001);
    step(1'b1, 24'hFFFF00, 2'd2, 1'b0, 1'b0, w);
    peek(1'b0, w); check("R3 negative leaves max", w, 32'h00010001);
    peek(1'b1, w); check("R4 negative min", w, 32'hFFFF0002);
    step(1'b1, 24'h000100, 2'd3, 1'b0, 1'b0, w);
    peek(1'b0, w); check("R5 equal keeps max chan", w, 32'h00010001);
    step(1'b1, 24'hFFFF00, 2'd0, 1'b0, 1'b0, w);
    peek(1'b1, w); check("R5 equal keeps min chan", w, 32'hFFFF0002);
    step(1'b1, 24'h7FFFFF, 2'd3, 1'b0, 1'b0, w);
    peek(1'b0, w); check("R3 most positive max", w, 32'h7FFFFF03);
  endtask

  task automatic t_read_max;
    logic [31:0] w;
    step(1'b0, 24'h0, 2'd0, 1'b1, 1'b0, w);
    check("R6 read max returns old", w, 32'h7FFFFF03);
    peek(1'b0, w); check("R7 max reloaded", w, 32'h80000000);
    peek(1'b1, w); check("R7 min untouched", w, 32'hFFFF0002);
  endtask

  task automatic t_read_min;
    logic [31:0] w;
    step(1'b0, 24'h0, 2'd0, 1'b1, 1'b1, w);
    check("R6 read min returns old", w, 32'hFFFF0002);
    peek(1'b1, w); check("R8 min reloaded", w, 32'h7FFFFF00);
    peek(1'b0, w); check("R8 max untouched", w, 32'h80000000);
  endtask

  task automatic t_same_cycle;
    logic [31:0] w;
    step(1'b1, 24'h000100, 2'd1, 1'b0, 1'b0, w);
    step(1'b1, 24'h000005, 2'd2, 1'b1, 1'b0, w);
    check("R9 read beside sample returns old", w, 32'h00010001);
    peek(1'b0, w); check("R9 smaller sample kept after reload", w, 32'h00000502);
    step(1'b1, 24'h800000, 2'd1, 1'b1, 1'b0, w);
    check("R9 second read returns old", w, 32'h00000502);
    peek(1'b0, w); check("R9 reload-equal sample not taken", w, 32'h80000000);
    peek(1'b1, w); check("R4 most negative min", w, 32'h80000001);
  endtask

  task automatic t_idle;
    logic [31:0] w;
    repeat (5) peek(1'b0, w);
    check("R10 max held idle", w, 32'h80000000);
    peek(1'b1, w); check("R10 min held idle", w, 32'h80000001);
  endtask

  task automatic t_stream;
    logic [31:0] w, exp;
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      exp = lfsr[29] ? word_of(m_min, m_minc) : word_of(m_max, m_maxc);
      step(1'b1, lfsr[23:0], lfsr[25:24], lfsr[28:27] == 2'b00, lfsr[29], w);
      check("R6 R9 stream read word", w, exp);
      if (w[7:2] !== 6'd0) check("R2 padding zero", w, exp & 32'hFFFFFF03);
    end
    exp = word_of(m_max, m_maxc);
    peek(1'b0, w); check("R3 stream final max", w, exp);
    exp = word_of(m_min, m_minc);
    peek(1'b1, w); check("R4 stream final min", w, exp);
  endtask

  initial begin
    m_max = 24'h800000; m_maxc = 2'd0;
    m_min = 24'h7FFFFF; m_minc = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_samples();
    t_read_max();
    t_read_min();
    t_same_cycle();
    t_idle();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule